// File: doc/BRIEF.md
# Master-Mode Audio Bit and Frame Clock Generator

This block produces the serial bit clock and the frame (word select) clock for an audio converter that drives its own serial port. It runs from the master clock and divides it according to three settings. The first is the master clock ratio, 256 or 512 master clocks per sample frame. The second is the frame format: a plain two-channel frame of 64 bits, a 128-bit time-division frame or a 256-bit time-division frame. The third is the framing style, either left-justified or I2S. The two-channel frame has a square frame clock. The time-division frames have a 32-bit pulse, and I2S framing inverts the level.

The clocks are driven only when the master/slave select is high. An active-low power-down input holds both clocks low. Any combination the block cannot or may not produce also holds both clocks low, and it raises a flag. A small state machine, with states OFF, SYNC and RUN, restarts the dividers whenever a setting changes. Because of this, the first frame after a change is always complete.

State machine transitions: OFF→SYNC when the block becomes enabled (master and legal settings). SYNC→RUN on the next clock if the settings are unchanged. RUN→SYNC or SYNC→SYNC when any setting differs from its value one clock earlier. Any state→OFF when disabled.

Top module: `acg_master_clkgen`

## Requirements
- R1: While `rst_n` is low, `bclk_o` and `fclk_o` are low. After release, a new frame starts from the beginning.
- R2: `cfg_bad` is high exactly when one of these holds, and while it is high both clocks are low:
  - `fmt_sel` = 2'b10 (reserved);
  - `mclk_sel`=1 (512 master clocks per frame) together with `rate_hi`=1 (above 48 kHz);
  - `fmt_sel` = 2'b01 (256-bit frame) together with `rate_hi`=1 or `mclk_sel`=0.
- R3: With `fmt_sel`=2'b00, each frame holds 64 bit clock periods. The frame clock is high during bits 0..31 and low during bits 32..63 (inverted when `i2s_mode`=1).
- R4: With `fmt_sel`=2'b01, each frame holds 256 bit clock periods. The frame clock is high only during bits 0..31 (low only, when `i2s_mode`=1).
- R5: With `fmt_sel`=2'b11, each frame holds 128 bit clock periods. The frame clock is high only during bits 0..31 (low only, when `i2s_mode`=1). This format is allowed with `rate_hi`=1 when `mclk_sel`=0.
- R6: `clk_oe` equals `is_master`. When `is_master` is low, both clocks are low from the next clock on.
- R7: Within a running frame sequence, `fclk_o` changes only on the clock where `bclk_o` falls.
- R8: A change of any setting sends the block through one SYNC clock with both clocks low. It then restarts at bit 0 with the bit clock low. The bit clock first rises after half a bit period.
- R9: The frame period is 256 master clocks when `mclk_sel`=0 and 512 when `mclk_sel`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low power-down, asynchronous |
| is_master | input | 1 | High: block drives the serial clocks |
| mclk_sel | input | 1 | 0: 256 master clocks per frame, 1: 512 |
| fmt_sel | input | 2 | 00 two-channel, 01 256-bit TDM, 11 128-bit TDM, 10 reserved |
| i2s_mode | input | 1 | Invert the frame clock level (I2S framing) |
| rate_hi | input | 1 | Sample rate above 48 kHz |
| bclk_o | output | 1 | Bit clock |
| fclk_o | output | 1 | Frame clock |
| clk_oe | output | 1 | Output enable for both clocks |
| cfg_bad | output | 1 | Unsupported setting combination |

## Verification
The hardest case to reach is a settings change that lands in the middle of a frame, away from any bit boundary. In that case the restart must discard a partial frame and begin a complete one. The stimulus lets a two-channel sequence run for an odd number of master clocks and then switches to a 128-bit frame. A behavioural model, which tracks elapsed time since the restart, predicts every clock level after that. A second case is power-down during a running frame, with the release checked the same way.

// File: rtl/acg_pkg.sv
package acg_pkg;
    localparam int BASE_LG   = 8;   // log2 of master clocks per frame at the low ratio
    localparam int SLOT_BITS = 32;  // bits per slot; frame clock pulse width
    localparam int BIT_W     = 8;   // holds bit index of the longest frame
    localparam int PH_W      = 2;   // holds the longest half-bit count

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_SYNC = 2'd1,
        ST_RUN  = 2'd2
    } gen_state_t;

    typedef enum logic [1:0] {
        FMT_NORM = 2'b00,
        FMT_T256 = 2'b01,
        FMT_RSV  = 2'b10,
        FMT_T128 = 2'b11
    } frame_fmt_t;

    typedef struct packed {
        logic       sel512;
        logic [1:0] fmt;
        logic       i2s;
    } clk_cfg_t;
endpackage

// File: rtl/acg_decode.sv
module acg_decode
    import acg_pkg::*;
(
    input  clk_cfg_t   cfg,
    input  logic       rate_hi,
    output logic       bad,
    output logic [1:0] half_lg,
    output logic [3:0] bits_lg
);
    int frame_lg;
    int hl;

    always_comb begin
        unique case (frame_fmt_t'(cfg.fmt))
            FMT_NORM: bits_lg = 4'd6;
            FMT_T256: bits_lg = 4'd8;
            FMT_T128: bits_lg = 4'd7;
            FMT_RSV:  bits_lg = 4'd6;
        endcase
        bad = (cfg.fmt == FMT_RSV)
            || (rate_hi && cfg.sel512)
            || ((cfg.fmt == FMT_T256) && (rate_hi || !cfg.sel512));
        frame_lg = BASE_LG + int'(cfg.sel512);
        hl       = frame_lg - int'(bits_lg) - 1;
        half_lg  = (bad || hl < 0) ? 2'd0 : 2'(hl);
    end
endmodule

// File: rtl/acg_fsm.sv
module acg_fsm
    import acg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  clk_cfg_t   cfg,
    output gen_state_t st_q,
    output gen_state_t st_d
);
    clk_cfg_t cfg_q;
    logic     changed;

    assign changed = (cfg != cfg_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_OFF;
            cfg_q <= '0;
        end else begin
            st_q  <= st_d;
            cfg_q <= cfg;
        end
    end

    always_comb begin
        st_d = ST_OFF;
        unique case (st_q)
            ST_OFF:  st_d = enable ? ST_SYNC : ST_OFF;
            ST_SYNC: st_d = !enable ? ST_OFF : (changed ? ST_SYNC : ST_RUN);
            ST_RUN:  st_d = !enable ? ST_OFF : (changed ? ST_SYNC : ST_RUN);
            default: st_d = ST_OFF;
        endcase
    end
endmodule

// File: rtl/acg_divider.sv
module acg_divider
    import acg_pkg::*;
#(
    parameter int SLOTS = SLOT_BITS
)(
    input  logic       clk,
    input  logic       rst_n,
    input  gen_state_t st_q,
    input  gen_state_t st_d,
    input  logic [1:0] half_lg,
    input  logic [3:0] bits_lg,
    input  logic       i2s,
    output logic       bclk,
    output logic       fclk
);
    logic [PH_W-1:0]  ph;
    logic [BIT_W-1:0] bitn;
    logic [PH_W-1:0]  half_m1;
    logic [BIT_W-1:0] bmask;
    logic [BIT_W-1:0] bit_nx;

    assign half_m1 = PH_W'((32'd1 << half_lg) - 32'd1);
    assign bmask   = BIT_W'((32'd1 << bits_lg) - 32'd1);
    assign bit_nx  = (bitn + BIT_W'(1)) & bmask;

    function automatic logic lvl(input logic [BIT_W-1:0] n, input logic inv);
        return (32'(n) < SLOTS) ^ inv;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph <= '0; bclk <= 1'b0; bitn <= '0; fclk <= 1'b0;
        end else if (st_d != ST_RUN) begin
            ph <= '0; bclk <= 1'b0; bitn <= '0; fclk <= 1'b0;
        end else if (st_q == ST_SYNC) begin
            ph <= '0; bclk <= 1'b0; bitn <= '0; fclk <= lvl('0, i2s);
        end else if (ph == half_m1) begin
            ph   <= '0;
            bclk <= ~bclk;
            if (bclk) begin
                bitn <= bit_nx;
                fclk <= lvl(bit_nx, i2s);
            end
        end else begin
            ph <= ph + PH_W'(1);
        end
    end

    // R7
    fclk_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && st_d == ST_RUN) |=> ($stable(fclk) || $fell(bclk)));
endmodule

// File: rtl/acg_master_clkgen.sv
module acg_master_clkgen
    import acg_pkg::*;
#(
    parameter int SLOTS = SLOT_BITS
)(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       is_master,
    input  logic       mclk_sel,
    input  logic [1:0] fmt_sel,
    input  logic       i2s_mode,
    input  logic       rate_hi,
    output logic       bclk_o,
    output logic       fclk_o,
    output logic       clk_oe,
    output logic       cfg_bad
);
    clk_cfg_t   cfg;
    logic       bad;
    logic [1:0] half_lg;
    logic [3:0] bits_lg;
    gen_state_t st_q, st_d;

    assign cfg     = '{sel512: mclk_sel, fmt: fmt_sel, i2s: i2s_mode};
    assign cfg_bad = bad;
    assign clk_oe  = is_master;

    acg_decode u_dec (
        .cfg(cfg), .rate_hi(rate_hi), .bad(bad),
        .half_lg(half_lg), .bits_lg(bits_lg)
    );

    acg_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .enable(is_master && !bad),
        .cfg(cfg), .st_q(st_q), .st_d(st_d)
    );

    acg_divider #(.SLOTS(SLOTS)) u_div (
        .clk(clk), .rst_n(rst_n), .st_q(st_q), .st_d(st_d),
        .half_lg(half_lg), .bits_lg(bits_lg), .i2s(i2s_mode),
        .bclk(bclk_o), .fclk(fclk_o)
    );

    // R6
    slave_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !is_master |=> (!bclk_o && !fclk_o));

    // R2
    bad_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_bad |=> (!bclk_o && !fclk_o));

    // R8
    sync_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SYNC) |-> (!bclk_o && !fclk_o));
endmodule

// File: tb/tb_acg_master_clkgen.sv
module tb_acg_master_clkgen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       is_master = 1'b1;
    logic       mclk_sel = 1'b0;
    logic [1:0] fmt_sel = 2'b00;
    logic       i2s_mode = 1'b0;
    logic       rate_hi = 1'b0;
    logic       bclk_o, fclk_o, clk_oe, cfg_bad;

    int n_total = 0;
    int n_bad   = 0;

    // behavioural model state
    int  ms = 0;            // 0 off, 1 sync, 2 run
    int  t = 0;             // edges since entering run
    int  prev_cfg = 0;
    int  cyc = 0;
    int  last_rise = -1;
    logic pb = 1'b0, pf = 1'b0;
    bit  prev_run = 0;

    always #10 clk = ~clk;

    acg_master_clkgen dut (
        .clk(clk), .rst_n(rst_n), .is_master(is_master), .mclk_sel(mclk_sel),
        .fmt_sel(fmt_sel), .i2s_mode(i2s_mode), .rate_hi(rate_hi),
        .bclk_o(bclk_o), .fclk_o(fclk_o), .clk_oe(clk_oe), .cfg_bad(cfg_bad)
    );

    task automatic chk(input string tag, input string what, input logic a, input logic e);
        n_total++;
        if (a !== e) begin
            n_bad++;
            $display("FAIL %s %s act=%0b exp=%0b (cycle %0d)", tag, what, a, e, cyc);
        end
    endtask

    function automatic bit bad_rule();
        return (fmt_sel == 2'b10) || (rate_hi && mclk_sel)
            || (fmt_sel == 2'b01 && (rate_hi || !mclk_sel));
    endfunction

    task automatic tick(input string tag);
        int cfgv, frame, bits, half, bitn;
        logic eb, ef;
        @(posedge clk);
        cyc++;
        cfgv = {mclk_sel, fmt_sel, i2s_mode};
        if (!rst_n) begin
            ms = 0; t = 0; prev_cfg = 0;
        end else begin
            if (!(is_master && !bad_rule())) ms = 0;
            else if (ms == 0 || cfgv != prev_cfg) ms = 1;
            else if (ms == 1) begin ms = 2; t = 0; end
            else t++;
            prev_cfg = cfgv;
        end
        frame = 256 << mclk_sel;
        bits  = (fmt_sel == 2'b01) ? 256 : (fmt_sel == 2'b11) ? 128 : 64;
        half  = frame / bits / 2;
        if (ms != 2) begin
            eb = 1'b0; ef = 1'b0;
        end else begin
            eb   = ((t / half) % 2) == 1;
            bitn = (t / (2 * half)) % bits;
            ef   = (bitn < 32) ^ i2s_mode;
        end
        #5;
        chk(tag, "bclk_o", bclk_o, eb);
        chk(tag, "fclk_o", fclk_o, ef);
        chk("R6", "clk_oe", clk_oe, is_master);
        chk("R2", "cfg_bad", cfg_bad, bad_rule());
        // R7: frame clock moves only with a falling bit clock
        if (ms == 2 && prev_run && fclk_o !== pf)
            chk("R7", "bclk fell at fclk edge", pb & ~bclk_o, 1'b1);
        // R9: frame period in master clocks
        if (ms != 2) last_rise = -1;
        else if (fclk_o === 1'b1 && pf === 1'b0 && prev_run) begin
            if (last_rise >= 0) begin
                n_total++;
                if (cyc - last_rise != frame) begin
                    n_bad++;
                    $display("FAIL R9 frame period act=%0d exp=%0d", cyc - last_rise, frame);
                end
            end
            last_rise = cyc;
        end
        prev_run = (ms == 2);
        pb = bclk_o;
        pf = fclk_o;
    endtask

    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) tick(tag);
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end

    initial begin
        #3;
        chk("R1", "bclk_o in power-down", bclk_o, 1'b0);
        chk("R1", "fclk_o in power-down", fclk_o, 1'b0);
        run(3, "R1");
        #2 rst_n = 1'b1;
        run(600, "R3");
        mclk_sel = 1'b1; i2s_mode = 1'b1;
        run(1100, "R3");
        fmt_sel = 2'b11; mclk_sel = 1'b0; i2s_mode = 1'b0;
        run(600, "R5");
        rate_hi = 1'b1;
        run(300, "R5");
        rate_hi = 1'b0; mclk_sel = 1'b1; i2s_mode = 1'b1;
        run(1100, "R5");
        fmt_sel = 2'b01; i2s_mode = 1'b0;
        run(1100, "R4");
        i2s_mode = 1'b1;
        run(600, "R4");
        mclk_sel = 1'b0;
        run(50, "R2");
        fmt_sel = 2'b00; mclk_sel = 1'b1; rate_hi = 1'b1;
        run(50, "R2");
        fmt_sel = 2'b10; mclk_sel = 1'b0; rate_hi = 1'b0;
        run(50, "R2");
        fmt_sel = 2'b00; i2s_mode = 1'b0; is_master = 1'b0;
        run(100, "R6");
        is_master = 1'b1;
        run(300, "R3");
        run(137, "R8");
        fmt_sel = 2'b11;
        run(700, "R8");
        rst_n = 1'b0;
        run(20, "R1");
        rst_n = 1'b1;
        run(600, "R1");
        $display("  test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end
endmodule